// File: doc/BRIEF.md
# Method Decoder with Field Validation

This block takes pushed commands, each an 11-bit method index with a 32-bit data word, and decides what each one means. It resolves the index against a fixed, ascending list of contiguous method ranges, walking one range per clock. A resolved method lands on a slot. A slot either stores the data word into its own state register or fires a one-cycle command strobe toward an executor outside the block.

Before a slot acts, the data word is checked against that slot's legal-bit mask. Three things count as an error: an index that no range covers, a data word with a bit outside the slot's mask, and a command that the executor refuses. On any error the block records an exception word and the offending data word. It raises a host interrupt and holds until the host acknowledges. Every command, good or bad, ends with a one-cycle done pulse. Commands arrive one at a time over a valid/ready handshake.

Top module: `mdec_top`

## Requirements
- R1: After reset every state register reads zero, `host_irq_o` is low, `exc_word_o` and `exc_data_o` are zero, and `cmd_ready_o` is high.
- R2: `cmd_ready_o` is high only while the block is idle. After a command is accepted, `cmd_ready_o` stays low until `cmd_done_o` has pulsed for exactly one cycle for that command.
- R3: A legal store method with legal data latches the data into its state register. State registers are numbered in ascending method order: index 0 is method 0x000, indices 1..7 are 0x080..0x086, 8..14 are 0x088..0x08E, and 15..28 are 0x0C3..0x0D0. Register k is `state_o[32*k +: 32]`.
- R4: Methods 0x040, 0x050, 0x0C0 and 0x0C1 are execute slots. They pulse `cmd_strobe_o` bit 0, 1, 2 and 3 respectively for one cycle, present the data on `cmd_data_o`, and leave every state register unchanged.
- R5: A method index that lies in no range (for example 0x001, 0x0C2, 0x0D1 or 0x7FF) is illegal. It sets `exc_word_o` to index<<16 | 0x1, sets `exc_data_o` to the data word, and raises `host_irq_o`.
- R6: A data word with any bit set outside the slot's mask is an invalid bitfield. It sets `exc_word_o` to index<<16 | 0x3 and `exc_data_o` to the data word, and raises `host_irq_o`. It changes no state register and fires no strobe.
- R7: The slot masks are as follows. Tile-mode fields (0x080, 0x084, 0x088, 0x08C) use 0xFFF. X-size and x-offset fields (0x081, 0x085, 0x089, 0x08D) and both pitches (0x0C7, 0x0C8) use 0x7FFFF. Y-size and y-offset fields (0x082, 0x086, 0x08A, 0x08E) and the y count (0x0CA) use 0x1FFF. Z-size fields (0x083, 0x08B) use 0x7FF. Address-high fields (0x0C3, 0x0C5, 0x0CE) use 0xFF. The x count (0x0C9) uses 0xFFFF and the format word (0x0CB) uses 0x0333FFFF. All other slots accept any data.
- R8: If `cmd_err_i` is high in the cycle a strobe is active, the command fails. `exc_word_o` becomes index<<16 with low 16 bits zero, `exc_data_o` becomes the data word, and `host_irq_o` rises.
- R9: `host_irq_o` stays high and `cmd_ready_o` stays low until `host_ack_i` is seen. Only then does `cmd_done_o` pulse.
- R10: A successful command leaves `exc_word_o` and `exc_data_o` holding the values of the last error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle and able to take a command |
| cmd_mthd_i | input | 11 | Method index |
| cmd_data_i | input | 32 | Command data word |
| state_o | output | 928 | Flattened state registers, 29 x 32 bits |
| cmd_strobe_o | output | 4 | One-hot execute strobes |
| cmd_data_o | output | 32 | Data accompanying a strobe |
| cmd_err_i | input | 1 | Executor rejects the strobed command |
| exc_word_o | output | 32 | Last exception word |
| exc_data_o | output | 32 | Data word of the last error |
| host_irq_o | output | 1 | Host interrupt request |
| host_ack_i | input | 1 | Host clears the interrupt |
| cmd_done_o | output | 1 | Command acknowledged, one-cycle pulse |

## Verification
Store methods are tried at the first range, inside the middle ranges, and at the last slot of the final range. A wrong base accumulation across the walk would therefore put data in the wrong register. Illegal indices are taken from a gap before the first range, from a hole between two adjacent ranges, and from the top of the index space, which must fall through to the sentinel. Mask checks drive each tested mask with its all-ones value and with the first bit above it. This separates an off-by-one mask from a correct one. An executor rejection is injected to show that error path apart from the decoder's own errors.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int MTHD_W     = 11;
  localparam int DATA_W     = 32;
  localparam int NUM_RANGES = 8;   // last entry is the sentinel
  localparam int NUM_SLOTS  = 33;
  localparam int NUM_STATE  = 29;
  localparam int NUM_CMD    = 4;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int RPTR_W     = $clog2(NUM_RANGES);
  localparam int STATE_W    = $clog2(NUM_STATE);
  localparam int CMD_W      = $clog2(NUM_CMD);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_CHECK, ST_EXEC, ST_WAIT, ST_DONE
  } fsm_e;

  function automatic logic [MTHD_W:0] range_start(input int r);
    case (r)
      0: return 12'h000;
      1: return 12'h040;
      2: return 12'h050;
      3: return 12'h080;
      4: return 12'h088;
      5: return 12'h0C0;
      6: return 12'h0C3;
      default: return 12'h800;
    endcase
  endfunction

  function automatic logic [MTHD_W:0] range_len(input int r);
    case (r)
      0, 1, 2: return 12'd1;
      3, 4:    return 12'd7;
      5:       return 12'd2;
      6:       return 12'd14;
      default: return 12'd0;
    endcase
  endfunction

  function automatic logic slot_is_cmd(input int s);
    return (s == 1) || (s == 2) || (s == 17) || (s == 18);
  endfunction

  function automatic int slot_state_idx(input int s);
    if (s == 0)       return 0;
    else if (s <= 16) return s - 2;
    else              return s - 4;
  endfunction

  function automatic int slot_cmd_idx(input int s);
    if (s == 1)       return 0;
    else if (s == 2)  return 1;
    else if (s == 17) return 2;
    else              return 3;
  endfunction

  function automatic logic [DATA_W-1:0] tile_mask(input int j);
    case (j)
      0, 4:    return 32'h0000_0FFF;
      1, 5:    return 32'h0007_FFFF;
      2, 6:    return 32'h0000_1FFF;
      default: return 32'h0000_07FF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(input int s);
    if (s >= 3 && s <= 16) return tile_mask((s - 3) % 7);
    case (s)
      19, 21, 30: return 32'h0000_00FF;
      23, 24:     return 32'h0007_FFFF;
      25:         return 32'h0000_FFFF;
      26:         return 32'h0000_1FFF;
      27:         return 32'h0333_FFFF;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/mdec_range_walker.sv
module mdec_range_walker
  import mdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              advance_i,
  input  logic [MTHD_W-1:0] mthd_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [RPTR_W-1:0] ptr_q;
  logic [SLOT_W-1:0] base_q;
  logic [MTHD_W:0]   lo, hi, len, idx_ext, off;

  always_comb begin
    lo      = range_start(int'(ptr_q));
    len     = range_len(int'(ptr_q));
    hi      = lo + len;
    idx_ext = {1'b0, mthd_i};
    off     = idx_ext - lo;
    miss_o  = idx_ext < lo;
    hit_o   = !miss_o && (idx_ext < hi);
    slot_o  = base_q + off[SLOT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (start_i) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (advance_i) begin
      ptr_q  <= ptr_q + 1'b1;
      base_q <= base_q + len[SLOT_W-1:0];
    end
  end

  // R5
  walk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && !start_i |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/mdec_field_check.sv
module mdec_field_check
  import mdec_pkg::*;
(
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               bad_o,
  output logic               is_cmd_o,
  output logic [STATE_W-1:0] state_idx_o,
  output logic [CMD_W-1:0]   cmd_idx_o
);
  logic [DATA_W-1:0] mask;
  int s, si, ci;

  always_comb begin
    s           = int'(slot_i);
    mask        = slot_mask(s);
    bad_o       = |(data_i & ~mask);
    is_cmd_o    = slot_is_cmd(s);
    si          = slot_state_idx(s);
    ci          = slot_cmd_idx(s);
    state_idx_o = si[STATE_W-1:0];
    cmd_idx_o   = ci[CMD_W-1:0];
  end
endmodule

// File: rtl/mdec_state_file.sv
module mdec_state_file
  import mdec_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [STATE_W-1:0]          widx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_STATE*DATA_W-1:0] state_o
);
  for (genvar k = 0; k < NUM_STATE; k++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (we_i && widx_i == STATE_W'(k))       q <= wdata_i;
    end
    assign state_o[k*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/mdec_top.sv
module mdec_top
  import mdec_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  output logic                        cmd_ready_o,
  input  logic [MTHD_W-1:0]           cmd_mthd_i,
  input  logic [DATA_W-1:0]           cmd_data_i,
  output logic [NUM_STATE*DATA_W-1:0] state_o,
  output logic [NUM_CMD-1:0]          cmd_strobe_o,
  output logic [DATA_W-1:0]           cmd_data_o,
  input  logic                        cmd_err_i,
  output logic [DATA_W-1:0]           exc_word_o,
  output logic [DATA_W-1:0]           exc_data_o,
  output logic                        host_irq_o,
  input  logic                        host_ack_i,
  output logic                        cmd_done_o
);
  localparam int PAD_W = 16 - MTHD_W;

  fsm_e               st_q;
  logic [MTHD_W-1:0]  mthd_q;
  logic [DATA_W-1:0]  data_q, exc_word_q, exc_data_q;
  logic [SLOT_W-1:0]  slot_q, walk_slot;
  logic               irq_q, walk_hit, walk_miss, accept;
  logic               chk_bad, chk_cmd, st_we;
  logic [STATE_W-1:0] st_idx;
  logic [CMD_W-1:0]   cmd_idx;

  assign accept = (st_q == ST_IDLE) && cmd_valid_i;

  mdec_range_walker u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .advance_i (st_q == ST_SCAN && !walk_hit && !walk_miss),
    .mthd_i    (mthd_q),
    .hit_o     (walk_hit),
    .miss_o    (walk_miss),
    .slot_o    (walk_slot)
  );

  mdec_field_check u_chk (
    .slot_i      (slot_q),
    .data_i      (data_q),
    .bad_o       (chk_bad),
    .is_cmd_o    (chk_cmd),
    .state_idx_o (st_idx),
    .cmd_idx_o   (cmd_idx)
  );

  assign st_we = (st_q == ST_CHECK) && !chk_bad && !chk_cmd;

  mdec_state_file u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (st_we),
    .widx_i  (st_idx),
    .wdata_i (data_q),
    .state_o (state_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mthd_q     <= '0;
      data_q     <= '0;
      slot_q     <= '0;
      exc_word_q <= '0;
      exc_data_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          mthd_q <= cmd_mthd_i;
          data_q <= cmd_data_i;
          st_q   <= ST_SCAN;
        end
        ST_SCAN: if (walk_miss) begin
          exc_word_q <= {{PAD_W{1'b0}}, mthd_q, 16'h0001};
          exc_data_q <= data_q;
          irq_q      <= 1'b1;
          st_q       <= ST_WAIT;
        end else if (walk_hit) begin
          slot_q <= walk_slot;
          st_q   <= ST_CHECK;
        end
        ST_CHECK: if (chk_bad) begin
          exc_word_q <= {{PAD_W{1'b0}}, mthd_q, 16'h0003};
          exc_data_q <= data_q;
          irq_q      <= 1'b1;
          st_q       <= ST_WAIT;
        end else begin
          st_q <= chk_cmd ? ST_EXEC : ST_DONE;
        end
        ST_EXEC: if (cmd_err_i) begin
          exc_word_q <= {{PAD_W{1'b0}}, mthd_q, 16'h0000};
          exc_data_q <= data_q;
          irq_q      <= 1'b1;
          st_q       <= ST_WAIT;
        end else begin
          st_q <= ST_DONE;
        end
        ST_WAIT: if (host_ack_i) begin
          irq_q <= 1'b0;
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_strobe_o = '0;
    if (st_q == ST_EXEC) cmd_strobe_o[cmd_idx] = 1'b1;
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign cmd_done_o  = (st_q == ST_DONE);
  assign cmd_data_o  = data_q;
  assign exc_word_o  = exc_word_q;
  assign exc_data_o  = exc_data_q;
  assign host_irq_o  = irq_q;

  // R4
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_strobe_o));
  // R4
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |cmd_strobe_o |=> !(|cmd_strobe_o));
  // R3
  slot_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN && walk_hit) |-> walk_slot < SLOT_W'(NUM_SLOTS));
  // R2
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |=> !cmd_done_o && cmd_ready_o);
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o && !host_ack_i |=> host_irq_o);
  // R9
  ready_low_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> !cmd_ready_o);
endmodule

// File: tb/mdec_top_tb_top.sv
module mdec_top_tb_top;
  import mdec_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, ack = 1'b0, err_mode = 1'b0;
  logic [MTHD_W-1:0] mthd = '0;
  logic [DATA_W-1:0] data = '0;
  logic ready, irq, done, cmd_err;
  logic [NUM_STATE*DATA_W-1:0] state;
  logic [NUM_CMD-1:0] strobe;
  logic [DATA_W-1:0] sdata, exc_word, exc_data;
  int checks = 0, errors = 0, strobe_cnt = 0;
  logic [NUM_CMD-1:0] last_strobe = '0;
  logic [DATA_W-1:0] last_sdata = '0;
  bit hung = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign cmd_err = err_mode && (|strobe);

  mdec_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_mthd_i(mthd), .cmd_data_i(data), .state_o(state),
    .cmd_strobe_o(strobe), .cmd_data_o(sdata), .cmd_err_i(cmd_err),
    .exc_word_o(exc_word), .exc_data_o(exc_data), .host_irq_o(irq),
    .host_ack_i(ack), .cmd_done_o(done)
  );

  always @(posedge clk) if (|strobe) begin
    strobe_cnt  <= strobe_cnt + 1;
    last_strobe <= strobe;
    last_sdata  <= sdata;
  end

  function automatic logic [31:0] st(input int k);
    return state[k*32 +: 32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [10:0] m, input logic [31:0] d);
    int n = 0;
    @(negedge clk);
    while (!ready && n < 200) begin @(negedge clk); n++; end
    valid = 1'b1; mthd = m; data = d;
    @(negedge clk);
    valid = 1'b0;
    check("R2 busy after accept", {31'b0, ready}, 32'd0);
  endtask

  // waits for done or irq; returns 1 if irq came first
  task automatic wait_end(output bit got_irq);
    int n = 0;
    got_irq = 0;
    while (!done && !irq && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) begin hung = 1; check("watchdog", 32'd1, 32'd0); end
    got_irq = irq;
  endtask

  task automatic clear_irq();
    int n = 0;
    repeat (3) @(negedge clk);
    check("R9 irq held", {31'b0, irq}, 32'd1);
    check("R9 ready low while irq", {31'b0, ready}, 32'd0);
    check("R9 no done before ack", {31'b0, done}, 32'd0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    check("R9 done after ack", {31'b0, done}, 32'd1);
    check("R9 irq cleared", {31'b0, irq}, 32'd0);
  endtask

  task automatic do_ok(input string req, input logic [10:0] m, input logic [31:0] d);
    bit g;
    send(m, d);
    wait_end(g);
    check({req, " no error"}, {31'b0, g}, 32'd0);
    check("R2 done pulse", {31'b0, done}, 32'd1);
    @(negedge clk);
    check("R2 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic do_err(input string req, input logic [10:0] m, input logic [31:0] d,
                        input logic [31:0] exp_word);
    bit g;
    send(m, d);
    wait_end(g);
    check({req, " irq raised"}, {31'b0, g}, 32'd1);
    check({req, " exc word"}, exc_word, exp_word);
    check({req, " exc data"}, exc_data, d);
    clear_irq();
  endtask

  task automatic t_reset();
    check("R1 ready", {31'b0, ready}, 32'd1);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 exc word", exc_word, 32'd0);
    check("R1 exc data", exc_data, 32'd0);
    for (int k = 0; k < NUM_STATE; k++) check("R1 state zero", st(k), 32'd0);
  endtask

  task automatic t_store();
    int c0 = strobe_cnt;
    do_ok("R3", 11'h000, 32'hDEAD_BEEF);
    check("R3 state0", st(0), 32'hDEAD_BEEF);
    do_ok("R3", 11'h080, 32'h0000_0ABC);
    check("R3 state1", st(1), 32'h0000_0ABC);
    do_ok("R3", 11'h08E, 32'h0000_1234);
    check("R3 state14", st(14), 32'h0000_1234);
    do_ok("R3", 11'h0D0, 32'hCAFE_F00D);
    check("R3 state28", st(28), 32'hCAFE_F00D);
    do_ok("R7", 11'h0CB, 32'h0333_FFFF);
    check("R7 format full mask", st(23), 32'h0333_FFFF);
    do_ok("R7", 11'h083, 32'h0000_07FF);
    check("R7 zsize full mask", st(4), 32'h0000_07FF);
    check("R3 no strobe on store", strobe_cnt - c0, 32'd0);
  endtask

  task automatic t_exec();
    int c0 = strobe_cnt;
    do_ok("R4", 11'h040, 32'h0000_0005);
    check("R4 strobe count", strobe_cnt - c0, 32'd1);
    check("R4 strobe bit0", {28'b0, last_strobe}, 32'h1);
    check("R4 strobe data", last_sdata, 32'h0000_0005);
    do_ok("R4", 11'h0C1, 32'h1111_2222);
    check("R4 strobe bit3", {28'b0, last_strobe}, 32'h8);
    check("R4 state untouched", st(0), 32'hDEAD_BEEF);
  endtask

  task automatic t_illegal();
    do_err("R5 gap", 11'h001, 32'h0000_0042, 32'h0001_0001);
    do_err("R5 hole", 11'h0C2, 32'h0000_0043, 32'h00C2_0001);
    do_err("R5 sentinel", 11'h7FF, 32'hFFFF_FFFF, 32'h07FF_0001);
    do_ok("R10", 11'h0C4, 32'h0000_0077);
    check("R10 exc word kept", exc_word, 32'h07FF_0001);
    check("R10 exc data kept", exc_data, 32'hFFFF_FFFF);
  endtask

  task automatic t_badfield();
    int c0 = strobe_cnt;
    do_err("R6 tile", 11'h080, 32'h0000_1000, 32'h0080_0003);
    check("R6 state1 kept", st(1), 32'h0000_0ABC);
    do_err("R7 zsize", 11'h083, 32'h0000_0800, 32'h0083_0003);
    check("R7 state4 kept", st(4), 32'h0000_07FF);
    do_err("R7 format", 11'h0CB, 32'h0400_0000, 32'h00CB_0003);
    do_err("R7 addr high", 11'h0C3, 32'h0000_0100, 32'h00C3_0003);
    check("R6 no strobe", strobe_cnt - c0, 32'd0);
  endtask

  task automatic t_cmd_err();
    int c0 = strobe_cnt;
    err_mode = 1'b1;
    do_err("R8", 11'h0C0, 32'h0000_00AA, 32'h00C0_0000);
    err_mode = 1'b0;
    check("R8 strobe seen", strobe_cnt - c0, 32'd1);
    check("R8 strobe bit2", {28'b0, last_strobe}, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    if (!hung) t_store();
    if (!hung) t_exec();
    if (!hung) t_illegal();
    if (!hung) t_badfield();
    if (!hung) t_cmd_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule